// File: doc/BRIEF.md
# Single-Wire Bus Master Controller

This block is the master end of a single-wire, open-drain serial bus of the kind used by battery fuel gauges. A host drives it through a small byte-wide register port. The host loads a byte and sets a start bit, and the block then does one of three things. It can shift the byte onto the wire, least significant bit first, with each bit coded as a short or a long low pulse. It can gather eight bits that the slave drives back. It can pull the wire low for a long break that puts the slave into a known state.

When an operation ends, the start bit and the break bit clear themselves, and one of three sticky flags is set. The flags are transmit done, receive done and timeout. A break reports its end through the timeout flag. Reading the flag register returns the flags and clears them. An interrupt line reports any pending flag while the interrupt enable bit is set. A soft-reset bit returns every register to its reset value and aborts a running operation. A status bit then reports that the reset has finished.

Every bus timing (break low, break recovery, bit slot, short and long pulse, receive sample point and receive timeout) is a parameter counted in clock cycles.

Top module: `sw_bus_master`

## Requirements
- R1: After reset, and before any host access: the control, flag, transmit, receive and config registers read 0. The wire is released and the interrupt line is low. One cycle after reset ends, the system status register (offset 0x18) reads 0x01.
- R2: The revision register at offset 0x00 reads {REV_MAJOR, REV_MINOR} (upper nibble, lower nibble). Writes to it have no effect.
- R3: Writing control (offset 0x0C) with bit 4 (start) = 1, bit 2 (break) = 0 and bit 1 (direction) = 0 sends the transmit register (offset 0x04) least significant bit first. Each bit slot is SLOT_CYC cycles long and begins with a drive-low of ONE_LOW_CYC cycles for a 1 or ZERO_LOW_CYC cycles for a 0. After the eighth slot, flag bit 2 is set and control bits 4 and 2 read 0.
- R4: Writing control with bit 4 = 1 and bit 2 = 1 drives the wire low for BRK_LOW_CYC cycles and then releases it for BRK_REC_CYC cycles. At the end, flag bit 0 is set and control bits 4 and 2 read 0.
- R5: Writing control with bit 4 = 1, bit 2 = 0 and bit 1 = 1 receives eight bits, least significant first, without driving the wire. Each bit is timed from a falling edge driven by the slave and sampled SAMPLE_CYC cycles later: a line still low reads as 0. The byte lands in the receive register (offset 0x08), flag bit 1 is set and control bit 4 reads 0.
- R6: During a receive, if no falling edge arrives within RX_TIMEOUT_CYC cycles of the previous bit (or of the start), the receive ends. Flag bit 0 is set, flag bit 1 stays 0, the receive register keeps its old value and control bit 4 reads 0.
- R7: A read of the flag register (offset 0x10) returns the pending flags and clears them, so an immediately repeated read returns 0.
- R8: The interrupt output is high exactly while control bit 6 is 1 and some flag is pending. With bit 6 = 0 the interrupt stays low, and bits 4 and 2 still clear at the end of the operation.
- R9: While an operation is running, writes to the control register are ignored. The register reads back unchanged, and the running operation completes with only its own flag.
- R10: Writing config (offset 0x14) with bit 1 = 1 returns all registers to their reset values and releases the wire at once. In the next cycle system status reads 0x00, and from the cycle after that it reads 0x01. Config bit 1 always reads 0.
- R11: Config bit 0 (auto-idle) and control bits 6, 5 (clock enable) and 0 (mode) are stored and read back. Control bits 7 and 3 read 0. A control write with bit 4 = 0 starts nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | 5 | Register byte offset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (clears flags when addr is 0x10) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for addr, combinational |
| irq | output | 1 | Interrupt request |
| line_drive_low | output | 1 | Open-drain enable: 1 pulls the wire low |
| line_in | input | 1 | Wire level as seen at the pad |

## Verification
Four rules are checked on every cycle by assertions:
- The start and break bits clear at the end of every operation.
- A control write during a busy operation leaves the register untouched.
- A flag read empties the flags.
- Soft reset lands on default values with the wire released.

They also check that the master never pulls the wire during a receive. The rest can only be shown by the bench's scenarios, with random bytes both ways and directed cases:
- the exact pulse widths, slot spacing and bit order on the wire;
- the byte recovered from a slave;
- the receive timeout;
- the break length;
- interrupt gating;
- the reset-done sequence.

// File: rtl/swb_pkg.sv
// Package: register offsets, bit positions and shared types of the
// single-wire bus master. Assumes byte-addressed host accesses.
package swb_pkg;
    localparam int unsigned ADDR_W = 5;
    localparam int unsigned DATA_W = 8;

    localparam logic [ADDR_W-1:0] A_REV  = 5'h00;
    localparam logic [ADDR_W-1:0] A_TXD  = 5'h04;
    localparam logic [ADDR_W-1:0] A_RXD  = 5'h08;
    localparam logic [ADDR_W-1:0] A_CTRL = 5'h0C;
    localparam logic [ADDR_W-1:0] A_FLAG = 5'h10;
    localparam logic [ADDR_W-1:0] A_CFG  = 5'h14;
    localparam logic [ADDR_W-1:0] A_STAT = 5'h18;

    // control bits
    localparam int B_IE   = 6;
    localparam int B_CKEN = 5;
    localparam int B_GO   = 4;
    localparam int B_INIT = 2;
    localparam int B_DIR  = 1;
    localparam int B_MODE = 0;
    localparam logic [DATA_W-1:0] CTRL_MASK = 8'h77;

    // flag bits
    localparam int F_TX = 2;
    localparam int F_RX = 1;
    localparam int F_TO = 0;

    // config bits
    localparam int C_SRST = 1;
    localparam int C_IDLE = 0;

    typedef enum logic [1:0] {OP_TX, OP_RX, OP_BRK} op_e;

    typedef struct packed {
        logic              tx;
        logic              rx;
        logic              to;
        logic [DATA_W-1:0] data;
    } done_t;
endpackage

// File: rtl/swb_regs.sv
// Register file: decodes host accesses, holds control, data, flags and
// config, raises the start request and the interrupt. Assumes the
// sequencer reports one done pulse per operation while busy is high.
module swb_regs
    import swb_pkg::*;
#(
    parameter logic [3:0] REV_MAJOR = 4'd2,
    parameter logic [3:0] REV_MINOR = 4'd1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              busy,
    input  done_t             done,
    output logic              start,
    output op_e               start_op,
    output logic              srst,
    output logic [DATA_W-1:0] txd_o,
    output logic [DATA_W-1:0] ctrl_o,
    output logic [2:0]        flags_o,
    output logic              rst_done_o,
    output logic              irq
);
    logic [DATA_W-1:0] ctrl_q, txd_q, rxd_q;
    logic [2:0]        flags_q, flags_d;
    logic              idle_q, rst_done_q;
    logic              wr_ctrl, rd_flag, any_done;

    assign wr_ctrl  = wr_en && (addr == A_CTRL);
    assign rd_flag  = rd_en && (addr == A_FLAG);
    assign srst     = wr_en && (addr == A_CFG) && wdata[C_SRST];
    assign start    = wr_ctrl && !busy && wdata[B_GO];
    assign any_done = done.tx | done.rx | done.to;

    // Pick the operation from the break and direction bits of the write.
    always_comb begin
        if (wdata[B_INIT])     start_op = OP_BRK;
        else if (wdata[B_DIR]) start_op = OP_RX;
        else                   start_op = OP_TX;
    end

    // Next flags: a read clears, a completion sets (setting wins).
    always_comb begin
        flags_d = rd_flag ? 3'b000 : flags_q;
        if (done.tx) flags_d[F_TX] = 1'b1;
        if (done.rx) flags_d[F_RX] = 1'b1;
        if (done.to) flags_d[F_TO] = 1'b1;
    end

    // Register state, with hardware and soft reset both synchronous.
    always_ff @(posedge clk) begin
        if (!rst_n || srst) begin
            ctrl_q     <= '0;
            txd_q      <= '0;
            rxd_q      <= '0;
            flags_q    <= '0;
            idle_q     <= 1'b0;
            rst_done_q <= 1'b0;
        end else begin
            rst_done_q <= 1'b1;
            flags_q    <= flags_d;
            if (wr_en && addr == A_TXD) txd_q <= wdata;
            if (wr_en && addr == A_CFG) idle_q <= wdata[C_IDLE];
            if (done.rx) rxd_q <= done.data;
            if (wr_ctrl && !busy) begin
                ctrl_q <= wdata & CTRL_MASK;
            end else if (any_done) begin
                ctrl_q[B_GO]   <= 1'b0;
                ctrl_q[B_INIT] <= 1'b0;
            end
        end
    end

    // Read multiplexer.
    always_comb begin
        case (addr)
            A_REV:   rdata = {REV_MAJOR, REV_MINOR};
            A_TXD:   rdata = txd_q;
            A_RXD:   rdata = rxd_q;
            A_CTRL:  rdata = ctrl_q;
            A_FLAG:  rdata = {5'b0, flags_q};
            A_CFG:   rdata = {7'b0, idle_q};
            A_STAT:  rdata = {7'b0, rst_done_q};
            default: rdata = '0;
        endcase
    end

    assign irq        = ctrl_q[B_IE] && (flags_q != 3'b000);
    assign txd_o      = txd_q;
    assign ctrl_o     = ctrl_q;
    assign flags_o    = flags_q;
    assign rst_done_o = rst_done_q;
endmodule

// File: rtl/swb_seq.sv
// Operation sequencer and line driver: generates break and bit-slot
// timing, shifts a byte out LSB first, and receives a byte by timing
// from the slave's falling edges. Assumes ONE_LOW_CYC < SLOT_CYC and
// ZERO_LOW_CYC < SLOT_CYC. The line input is asynchronous, so it is
// synchronised.
module swb_seq
    import swb_pkg::*;
#(
    parameter int unsigned BRK_LOW_CYC    = 1900,
    parameter int unsigned BRK_REC_CYC    = 400,
    parameter int unsigned SLOT_CYC       = 1900,
    parameter int unsigned ONE_LOW_CYC    = 320,
    parameter int unsigned ZERO_LOW_CYC   = 1000,
    parameter int unsigned SAMPLE_CYC     = 600,
    parameter int unsigned RX_TIMEOUT_CYC = 4000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              abort,
    input  logic              start,
    input  op_e               op,
    input  logic [DATA_W-1:0] txd,
    input  logic              line_in,
    output logic              drive_low,
    output logic              busy,
    output done_t             done
);
    localparam int CW = $clog2(BRK_LOW_CYC + BRK_REC_CYC + SLOT_CYC + RX_TIMEOUT_CYC + 1);
    localparam logic [CW-1:0] L_BLOW = CW'(BRK_LOW_CYC - 1);
    localparam logic [CW-1:0] L_BREC = CW'(BRK_REC_CYC - 1);
    localparam logic [CW-1:0] L_SLOT = CW'(SLOT_CYC - 1);
    localparam logic [CW-1:0] L_ONE  = CW'(ONE_LOW_CYC - 1);
    localparam logic [CW-1:0] L_ZERO = CW'(ZERO_LOW_CYC - 1);
    localparam logic [CW-1:0] L_SAMP = CW'(SAMPLE_CYC - 1);
    localparam logic [CW-1:0] L_TO   = CW'(RX_TIMEOUT_CYC - 1);
    localparam int BW = $clog2(DATA_W);
    localparam logic [BW-1:0] LAST_BIT = BW'(DATA_W - 1);

    typedef enum logic [2:0] {S_IDLE, S_BLOW, S_BREC, S_TLOW, S_TREST, S_RWAIT, S_RSLOT} st_e;

    st_e               state;
    logic [CW-1:0]     cnt, low_lim;
    logic [BW-1:0]     bitn;
    logic [DATA_W-1:0] sh;
    logic              s1, s2, s3, fall;

    assign low_lim = sh[0] ? L_ONE : L_ZERO;
    assign fall    = s3 && !s2;

    // Two-stage synchroniser plus one delay stage for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) {s1, s2, s3} <= 3'b111;
        else        {s1, s2, s3} <= {line_in, s1, s2};
    end

    // Operation state machine with slot counter and bit index.
    always_ff @(posedge clk) begin
        if (!rst_n || abort) begin
            state <= S_IDLE;
            cnt   <= '0;
            bitn  <= '0;
            sh    <= '0;
        end else begin
            case (state)
                S_IDLE: if (start) begin
                    cnt  <= '0;
                    bitn <= '0;
                    sh   <= txd;
                    case (op)
                        OP_BRK:  state <= S_BLOW;
                        OP_RX:   state <= S_RWAIT;
                        default: state <= S_TLOW;
                    endcase
                end
                S_BLOW: if (cnt == L_BLOW) begin
                    cnt   <= '0;
                    state <= S_BREC;
                end else cnt <= cnt + 1'b1;
                S_BREC: if (cnt == L_BREC) begin
                    cnt   <= '0;
                    state <= S_IDLE;
                end else cnt <= cnt + 1'b1;
                S_TLOW: begin
                    cnt <= cnt + 1'b1;
                    if (cnt == low_lim) state <= S_TREST;
                end
                S_TREST: if (cnt == L_SLOT) begin
                    cnt <= '0;
                    if (bitn == LAST_BIT) state <= S_IDLE;
                    else begin
                        bitn  <= bitn + 1'b1;
                        sh    <= sh >> 1;
                        state <= S_TLOW;
                    end
                end else cnt <= cnt + 1'b1;
                S_RWAIT: if (fall) begin
                    cnt   <= '0;
                    state <= S_RSLOT;
                end else if (cnt == L_TO) begin
                    cnt   <= '0;
                    state <= S_IDLE;
                end else cnt <= cnt + 1'b1;
                S_RSLOT: if (cnt == L_SAMP) begin
                    cnt <= '0;
                    sh  <= {s2, sh[DATA_W-1:1]};
                    if (bitn == LAST_BIT) state <= S_IDLE;
                    else begin
                        bitn  <= bitn + 1'b1;
                        state <= S_RWAIT;
                    end
                end else cnt <= cnt + 1'b1;
                default: state <= S_IDLE;
            endcase
        end
    end

    // Completion pulses in the last cycle of each operation.
    always_comb begin
        done.tx   = !abort && state == S_TREST && cnt == L_SLOT && bitn == LAST_BIT;
        done.rx   = !abort && state == S_RSLOT && cnt == L_SAMP && bitn == LAST_BIT;
        done.to   = !abort && ((state == S_BREC && cnt == L_BREC) ||
                               (state == S_RWAIT && !fall && cnt == L_TO));
        done.data = {s2, sh[DATA_W-1:1]};
    end

    assign drive_low = (state == S_BLOW) || (state == S_TLOW);
    assign busy      = (state != S_IDLE);
endmodule

// File: rtl/sw_bus_master.sv
// Top of the single-wire bus master: joins the register file to the
// sequencer. Assumes an external pull-up on the wire and a pad that
// returns the wire level on line_in.
module sw_bus_master
    import swb_pkg::*;
#(
    parameter logic [3:0]  REV_MAJOR      = 4'd2,
    parameter logic [3:0]  REV_MINOR      = 4'd1,
    parameter int unsigned BRK_LOW_CYC    = 1900,
    parameter int unsigned BRK_REC_CYC    = 400,
    parameter int unsigned SLOT_CYC       = 1900,
    parameter int unsigned ONE_LOW_CYC    = 320,
    parameter int unsigned ZERO_LOW_CYC   = 1000,
    parameter int unsigned SAMPLE_CYC     = 600,
    parameter int unsigned RX_TIMEOUT_CYC = 4000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [4:0] addr,
    input  logic       wr_en,
    input  logic       rd_en,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    output logic       irq,
    output logic       line_drive_low,
    input  logic       line_in
);
    logic              busy_w, start_w, srst_w, rst_done_w;
    op_e               op_w;
    done_t             done_w;
    logic [DATA_W-1:0] txd_w, ctrl_w;
    logic [2:0]        flags_w;

    swb_regs #(
        .REV_MAJOR(REV_MAJOR),
        .REV_MINOR(REV_MINOR)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
        .wdata(wdata), .rdata(rdata), .busy(busy_w), .done(done_w),
        .start(start_w), .start_op(op_w), .srst(srst_w), .txd_o(txd_w),
        .ctrl_o(ctrl_w), .flags_o(flags_w), .rst_done_o(rst_done_w), .irq(irq)
    );

    swb_seq #(
        .BRK_LOW_CYC(BRK_LOW_CYC), .BRK_REC_CYC(BRK_REC_CYC),
        .SLOT_CYC(SLOT_CYC), .ONE_LOW_CYC(ONE_LOW_CYC),
        .ZERO_LOW_CYC(ZERO_LOW_CYC), .SAMPLE_CYC(SAMPLE_CYC),
        .RX_TIMEOUT_CYC(RX_TIMEOUT_CYC)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .abort(srst_w), .start(start_w), .op(op_w),
        .txd(txd_w), .line_in(line_in), .drive_low(line_drive_low),
        .busy(busy_w), .done(done_w)
    );
endmodule

// File: rtl/swb_checker.sv
// Checker for the single-wire bus master: cycle-level rules between the
// host port, the register file and the sequencer. Bound to the top below.
module swb_checker
    import swb_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic [4:0]  addr,
    input logic        wr_en,
    input logic        rd_en,
    input logic [7:0]  wdata,
    input logic        line_drive_low,
    input logic [7:0]  ctrl_q,
    input logic [2:0]  flags_q,
    input logic        busy,
    input done_t       done,
    input logic        rst_done
);
    logic done_any;
    assign done_any = done.tx | done.rx | done.to;

    AST_GO_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        done_any |=> (!ctrl_q[B_GO] && !ctrl_q[B_INIT])); // R3

    AST_BUSY_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && wr_en && addr == A_CTRL && !done_any) |=> (ctrl_q == $past(ctrl_q))); // R9

    AST_FLAG_READ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == A_FLAG && !done_any) |=> (flags_q == 3'b000)); // R7

    AST_SRST_DEFAULTS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_CFG && wdata[C_SRST]) |=>
        (ctrl_q == 8'h00 && flags_q == 3'b000 && !line_drive_low && !rst_done)); // R10

    AST_READ_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && ctrl_q[B_DIR] && !ctrl_q[B_INIT]) |-> !line_drive_low); // R5
endmodule

bind sw_bus_master swb_checker u_chk (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .line_drive_low(line_drive_low), .ctrl_q(ctrl_w),
    .flags_q(flags_w), .busy(busy_w), .done(done_w), .rst_done(rst_done_w)
);

// File: tb/sw_bus_master_bench.sv
// Bench for the single-wire bus master: directed corner cases plus
// random bytes in both directions, with a behavioural slave on the wire.
module sw_bus_master_bench;
    localparam int BRK_LOW = 20;
    localparam int BRK_REC = 6;
    localparam int SLOT    = 20;
    localparam int ONE_LOW = 3;
    localparam int ZER_LOW = 10;
    localparam int SAMPLE  = 6;
    localparam int RX_TO   = 40;

    localparam logic [4:0] A_REV = 5'h00, A_TXD = 5'h04, A_RXD = 5'h08,
                           A_CTRL = 5'h0C, A_FLAG = 5'h10, A_CFG = 5'h14,
                           A_STAT = 5'h18;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] addr = '0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       irq, line_drive_low, slave_low = 1'b0, line;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;
    int widths[8];
    int starts[8];

    assign line = ~(line_drive_low | slave_low);

    always #4 clk = ~clk;

    sw_bus_master #(
        .REV_MAJOR(4'd2), .REV_MINOR(4'd1),
        .BRK_LOW_CYC(BRK_LOW), .BRK_REC_CYC(BRK_REC), .SLOT_CYC(SLOT),
        .ONE_LOW_CYC(ONE_LOW), .ZERO_LOW_CYC(ZER_LOW), .SAMPLE_CYC(SAMPLE),
        .RX_TIMEOUT_CYC(RX_TO)
    ) u_sw_bus_master (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
        .wdata(wdata), .rdata(rdata), .irq(irq),
        .line_drive_low(line_drive_low), .line_in(line)
    );

    function automatic int exp_width(input logic b);
        return b ? ONE_LOW : ZER_LOW;
    endfunction

    function automatic logic [7:0] exp_ctrl_after(input logic [7:0] c);
        return c & 8'h63;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // Both access tasks start and end at a falling edge.
    task automatic wr(input logic [4:0] a, input logic [7:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [7:0] d);
        addr = a; rd_en = 1'b1;
        #1 d = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic wait_idle(input string req);
        logic [7:0] v;
        int n = 0;
        rd(A_CTRL, v);
        while (v[4] && n < 2000) begin
            rd(A_CTRL, v);
            n++;
        end
        chk({req, " start bit self-clears"}, int'(v[4]), 0);
    endtask

    task automatic capture_tx();
        int n = 0, w = 0, cyc = 0;
        while (n < 8 && cyc < 2000) begin
            if (line_drive_low) begin
                if (w == 0) starts[n] = cyc;
                w++;
            end else if (w > 0) begin
                widths[n] = w;
                n++;
                w = 0;
            end
            @(negedge clk);
            cyc++;
        end
    endtask

    task automatic tx_run(input logic [7:0] b, input logic [7:0] c);
        logic [7:0] v;
        wr(A_TXD, b);
        wr(A_CTRL, c);
        capture_tx();
        for (int i = 0; i < 8; i++) chk("R3 pulse width", widths[i], exp_width(b[i]));
        for (int i = 0; i < 7; i++) chk("R3 slot spacing", starts[i+1] - starts[i], SLOT);
        wait_idle("R3");
        rd(A_CTRL, v);
        chk("R3 control after transmit", int'(v), int'(exp_ctrl_after(c)));
        chk("R8 irq with pending flag", int'(irq), int'(c[6]));
        rd(A_FLAG, v);
        chk("R3 transmit flag", int'(v), 4);
        rd(A_FLAG, v);
        chk("R7 flags cleared by read", int'(v), 0);
        chk("R8 irq after flag read", int'(irq), 0);
    endtask

    task automatic slave_send(input logic [7:0] b);
        int drv = 0;
        repeat (4) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            slave_low = 1'b1;
            for (int k = 0; k < SLOT; k++) begin
                if (k == exp_width(b[i])) slave_low = 1'b0;
                if (line_drive_low) drv++;
                @(negedge clk);
            end
        end
        slave_low = 1'b0;
        chk("R5 master leaves wire alone", drv, 0);
    endtask

    task automatic rx_run(input logic [7:0] b);
        logic [7:0] v;
        wr(A_CTRL, 8'h72);
        slave_send(b);
        wait_idle("R5");
        rd(A_RXD, v);
        chk("R5 received byte", int'(v), int'(b));
        rd(A_CTRL, v);
        chk("R5 control after receive", int'(v), 8'h62);
        rd(A_FLAG, v);
        chk("R5 receive flag", int'(v), 2);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] v, b, last_rx;
        int n;
        void'($urandom(32'd4242));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 wire released", int'(line_drive_low), 0);
        chk("R1 irq low", int'(irq), 0);
        rd(A_CTRL, v); chk("R1 control", int'(v), 0);
        rd(A_FLAG, v); chk("R1 flags", int'(v), 0);
        rd(A_TXD, v);  chk("R1 transmit reg", int'(v), 0);
        rd(A_RXD, v);  chk("R1 receive reg", int'(v), 0);
        rd(A_CFG, v);  chk("R1 config", int'(v), 0);
        rd(A_STAT, v); chk("R1 reset done", int'(v), 1);

        // R2 revision
        rd(A_REV, v); chk("R2 revision", int'(v), 8'h21);
        wr(A_REV, 8'hFF);
        rd(A_REV, v); chk("R2 revision after write", int'(v), 8'h21);

        // R11 storage without starting
        wr(A_CTRL, 8'hA9);
        rd(A_CTRL, v); chk("R11 control bits stored", int'(v), 8'h21);
        n = 0;
        repeat (10) begin if (line_drive_low) n++; @(negedge clk); end
        chk("R11 no start without start bit", n, 0);
        rd(A_FLAG, v); chk("R11 no flag without start bit", int'(v), 0);
        wr(A_CFG, 8'h01);
        rd(A_CFG, v); chk("R11 auto-idle stored", int'(v), 1);

        // R3 directed patterns then random
        tx_run(8'h00, 8'h70);
        tx_run(8'hFF, 8'h70);
        tx_run(8'hA5, 8'h71);
        for (int i = 0; i < 4; i++) tx_run(8'($urandom), 8'h70);

        // R4 break
        wr(A_CTRL, 8'h74);
        n = 0;
        while (line_drive_low && n < 1000) begin n++; @(negedge clk); end
        chk("R4 break low length", n, BRK_LOW);
        n = 0;
        rd(A_CTRL, v);
        while (v[4] && n < 200) begin rd(A_CTRL, v); n++; end
        chk("R4 control after break", int'(v), 8'h60);
        chk("R4 recovery within window", int'(n < BRK_REC + 2), 1);
        rd(A_FLAG, v); chk("R4 break reports timeout flag", int'(v), 1);

        // R5 receive, directed then random
        rx_run(8'h00);
        rx_run(8'hFF);
        for (int i = 0; i < 4; i++) rx_run(8'($urandom));
        rd(A_RXD, last_rx);

        // R6 receive timeout
        wr(A_CTRL, 8'h72);
        wait_idle("R6");
        rd(A_FLAG, v); chk("R6 timeout flag only", int'(v), 1);
        rd(A_RXD, v);  chk("R6 receive reg kept", int'(v), int'(last_rx));

        // R8 interrupt disabled
        wr(A_TXD, 8'h3C);
        wr(A_CTRL, 8'h30);
        wait_idle("R8");
        chk("R8 irq masked", int'(irq), 0);
        rd(A_CTRL, v); chk("R8 control after masked run", int'(v), 8'h20);
        rd(A_FLAG, v); chk("R8 flag still set", int'(v), 4);

        // R9 control write while busy
        wr(A_TXD, 8'h5A);
        wr(A_CTRL, 8'h70);
        wr(A_CTRL, 8'h0F);
        rd(A_CTRL, v); chk("R9 control unchanged while busy", int'(v), 8'h70);
        wait_idle("R9");
        rd(A_FLAG, v); chk("R9 only transmit flag", int'(v), 4);

        // R10 soft reset in the middle of a transmit
        wr(A_CFG, 8'h01);
        b = 8'($urandom);
        wr(A_TXD, b);
        wr(A_CTRL, 8'h70);
        repeat (2) @(negedge clk);
        wr(A_CFG, 8'h02);
        chk("R10 wire released", int'(line_drive_low), 0);
        rd(A_STAT, v); chk("R10 reset done cleared", int'(v), 0);
        rd(A_STAT, v); chk("R10 reset done set", int'(v), 1);
        rd(A_CTRL, v); chk("R10 control default", int'(v), 0);
        rd(A_CFG, v);  chk("R10 config default", int'(v), 0);
        rd(A_TXD, v);  chk("R10 transmit default", int'(v), 0);
        rd(A_FLAG, v); chk("R10 flags default", int'(v), 0);
        n = 0;
        repeat (SLOT) begin if (line_drive_low) n++; @(negedge clk); end
        chk("R10 operation aborted", n, 0);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule